// File: doc/BRIEF.md
# Three-Mode 24-Bit Timer/Counter

A bus-mapped timer built around one 24-bit up-counter and two compare values. Software picks one of four operating modes: an interval timer that stops or restarts at compare A; a pulse generator whose output toggles at compare A and at compare B, where compare B also restarts the count; a watchdog that restarts at compare A and keeps running even when the enable bit is clear; and a stopped mode. Each mode has its own sticky status flag and its own interrupt-enable bit.

The counter is advanced either by the system clock, directly or through a power-of-two prescaler, or by an external tick-enable input that is already synchronised to the clock. Software reaches the block over a 32-bit register port that has a word address, byte enables, a write strobe and combinational read data. The block drives a registered level interrupt and a toggling pulse output.

Top module: `tri_mode_timer`

## Requirements
- R1: Register offsets are: control 0x00, status 0x04, compare A 0x08, compare B 0x0C, interval setup 0x10, prescale divider 0x20, pulse setup 0x30, watchdog setup 0x40, and count 0xF0. The count register is read-only. Any other address reads 0, and a write to it changes nothing.
- R2: Control is byte 0, and bit 4 always reads 0. Compare A and compare B store byte lanes 0 to 2 only, and their top byte reads 0. In interval setup, bit 15 is the interrupt enable and bit 0 is clear-on-match. The divider register is bits 2:0. In pulse setup, bit 15 enables the B interrupt, bit 14 enables the A interrupt, and bit 0 is the initial output level. In watchdog setup, bit 15 is the interrupt enable, bit 7 is the disable bit and bit 0 is a plain stored bit. Bits 15:8 use byte enable 1, and bits 7:0 use byte enable 0.
- R3: On every clock edge where rst is high, pulse_out takes the value that the initial-level bit held before that edge. All registers, the counter, the flags and irq clear, and both compare registers return to 0x00FFFFFF. A reset that lasts one cycle therefore presets pulse_out.
- R4: Control bit 7 is enable, bit 6 enables the prescaler, bit 5 clears the counter when a write disables it, bit 2 selects the external source, and bits 1:0 select the mode (0 interval, 1 pulse, 2 watchdog, 3 stopped). With the external source, the counter steps once per cycle in which ext_tick is high. With the internal clock and no prescaler, it steps every clock. With the prescaler enabled, it steps once every 2^(D+1) clocks, where D is the divider value. The prescaler phase restarts on each control write, so the first step lands 2^(D+1) edges after that write.
- R5: A control write that has bit 7 = 0 and bit 5 = 1 clears the counter at that edge.
- R6: In interval mode, the counter steps only while enable is 1 and the count differs from compare A. When it reaches compare A, it sets status bit 0. It then loads 0 if clear-on-match is set, and otherwise holds at compare A.
- R7: In interval mode, irq is raised only at the arrival at compare A, and only if interval bit 15 is set. Holding at compare A never raises it again.
- R8: In pulse mode, which runs while enable is 1, reaching compare A toggles pulse_out and sets status bit 1, with irq if pulse bit 14 is set. pulse_out changes in no other mode.
- R9: In pulse mode, reaching compare B toggles pulse_out, sets status bit 2, clears the counter, and raises irq if pulse bit 15 is set.
- R10: In watchdog mode, the counter steps while enable is 1 or the disable bit is 0. Reaching compare A sets status bit 3, clears the counter, and raises irq if watchdog bit 15 is set.
- R11: In mode 3, the counter never steps, whatever the enable bit says.
- R12: Any write to the status offset clears all four flags and irq at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for a write |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ext_tick | input | 1 | External count enable, already synchronised |
| irq | output | 1 | Registered level interrupt |
| pulse_out | output | 1 | Pulse generator output |

## Verification
A register write takes effect at the edge that samples the strobe. Read data is combinational, so the bench reads back half a cycle after that edge. A counter step caused by ext_tick shows up in the count, the flags, irq and pulse_out at the same edge. The bench raises ext_tick for exactly one cycle and compares all four results with its own step model at the following falling edge. For the internal sources it counts edges from the control write: 2^(D+1) edges with the prescaler on, and one edge per step with it off. It samples once on each side of the edge where the step is due.

// File: rtl/tri_mode_timer.sv
module tri_mode_timer #(
  parameter int CNT_W = 24,
  parameter int DIV_W = 3,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic [3:0]    bus_be,
  input  logic          bus_we,
  output logic [31:0]   bus_rdata,
  input  logic          ext_tick,
  output logic          irq,
  output logic          pulse_out
);
  localparam int CMP_BYTES = CNT_W / 8;
  localparam int PRE_W = 2 ** DIV_W;
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00), A_STAT = AW'(8'h04),
    A_CMPA = AW'(8'h08), A_CMPB = AW'(8'h0C), A_IVAL = AW'(8'h10),
    A_DIV = AW'(8'h20), A_PULS = AW'(8'h30), A_WDOG = AW'(8'h40),
    A_CNT = AW'(8'hF0);

  logic [7:0]       ctrl_q;
  logic [3:0]       flag_q;
  logic [CNT_W-1:0] cmp_a, cmp_b, cnt_q, cnt_d, cnt_nx;
  logic             iv_ie, iv_zc, pg_ae, pg_be, pg_init, wd_ie, wd_dis, wd_bit0;
  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic             ff_q, irq_q, tick, tog, irq_ev;
  logic [3:0]       ev;

  wire en       = ctrl_q[7];
  wire [1:0] md = ctrl_q[1:0];
  wire ctrl_wr  = bus_we && bus_addr == A_CTRL && bus_be[0];
  wire stat_wr  = bus_we && bus_addr == A_STAT;
  wire cnt_clr  = ctrl_wr && !bus_wdata[7] && bus_wdata[5];

  assign pre_lim = PRE_W'((32'd2 << div_q) - 32'd1);
  assign tick    = ctrl_q[2] ? ext_tick : (!ctrl_q[6] || pre_q == pre_lim);
  assign cnt_nx  = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    ev    = '0;
    tog   = 1'b0;
    if (tick) begin
      case (md)
        2'd0: if (en && cnt_q != cmp_a) begin
          if (cnt_nx == cmp_a) begin
            ev[0] = 1'b1;
            cnt_d = iv_zc ? '0 : cmp_a;
          end else cnt_d = cnt_nx;
        end
        2'd1: if (en) begin
          if (cnt_nx == cmp_a) begin
            ev[1] = 1'b1;
            tog   = 1'b1;
            cnt_d = cnt_nx;
          end else if (cnt_nx == cmp_b) begin
            ev[2] = 1'b1;
            tog   = 1'b1;
            cnt_d = '0;
          end else cnt_d = cnt_nx;
        end
        2'd2: if (en || !wd_dis) begin
          if (cnt_nx == cmp_a) begin
            ev[3] = 1'b1;
            cnt_d = '0;
          end else cnt_d = cnt_nx;
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  assign irq_ev = (ev[0] & iv_ie) | (ev[1] & pg_ae) | (ev[2] & pg_be) | (ev[3] & wd_ie);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      flag_q <= '0;
      cnt_q  <= '0;
      pre_q  <= '0;
      irq_q  <= 1'b0;
      ff_q   <= pg_init;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata[7:0] & 8'hEF;
      cnt_q <= cnt_clr ? '0 : cnt_d;
      if (ctrl_wr || pre_q == pre_lim) pre_q <= '0;
      else pre_q <= pre_q + PRE_W'(1);
      if (stat_wr) begin
        flag_q <= '0;
        irq_q  <= 1'b0;
      end else begin
        flag_q <= flag_q | ev;
        irq_q  <= irq_q | irq_ev;
      end
      if (tog) ff_q <= ~ff_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {iv_ie, iv_zc, pg_ae, pg_be, pg_init, wd_ie, wd_dis, wd_bit0} <= '0;
      div_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_IVAL && bus_be[1]) iv_ie <= bus_wdata[15];
      if (bus_addr == A_IVAL && bus_be[0]) iv_zc <= bus_wdata[0];
      if (bus_addr == A_DIV && bus_be[0])  div_q <= bus_wdata[DIV_W-1:0];
      if (bus_addr == A_PULS && bus_be[1]) {pg_be, pg_ae} <= bus_wdata[15:14];
      if (bus_addr == A_PULS && bus_be[0]) pg_init <= bus_wdata[0];
      if (bus_addr == A_WDOG && bus_be[1]) wd_ie <= bus_wdata[15];
      if (bus_addr == A_WDOG && bus_be[0]) {wd_dis, wd_bit0} <= {bus_wdata[7], bus_wdata[0]};
    end
  end

  for (genvar b = 0; b < CMP_BYTES; b++) begin : g_cmp_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_a[8*b +: 8] <= 8'hFF;
        cmp_b[8*b +: 8] <= 8'hFF;
      end else if (bus_we && bus_be[b]) begin
        if (bus_addr == A_CMPA) cmp_a[8*b +: 8] <= bus_wdata[8*b +: 8];
        if (bus_addr == A_CMPB) cmp_b[8*b +: 8] <= bus_wdata[8*b +: 8];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {24'b0, ctrl_q};
      A_STAT:  bus_rdata = {28'b0, flag_q};
      A_CMPA:  bus_rdata = 32'(cmp_a);
      A_CMPB:  bus_rdata = 32'(cmp_b);
      A_IVAL:  bus_rdata = {16'b0, iv_ie, 14'b0, iv_zc};
      A_DIV:   bus_rdata = 32'(div_q);
      A_PULS:  bus_rdata = {16'b0, pg_be, pg_ae, 13'b0, pg_init};
      A_WDOG:  bus_rdata = {16'b0, wd_ie, 7'b0, wd_dis, 6'b0, wd_bit0};
      A_CNT:   bus_rdata = 32'(cnt_q);
      default: bus_rdata = '0;
    endcase
  end

  assign irq       = irq_q;
  assign pulse_out = ff_q;
endmodule

// File: rtl/tri_mode_timer_chk.sv
module tri_mode_timer_chk #(
  parameter int CNT_W = 24,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [3:0]       bus_be,
  input logic [31:0]      bus_wdata,
  input logic [7:0]       ctrl,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_a,
  input logic [3:0]       flags,
  input logic             irq,
  input logic             ff
);
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ctrl[1:0] == 2'd3 && !bus_we) |=> $stable(cnt)); // R11
  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(8'h04)) |=> (flags == 4'd0 && !irq)); // R12
  AST_INTERVAL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (ctrl[1:0] == 2'd0 && cnt <= cmp_a && !bus_we) |=> cnt <= cmp_a); // R6
  AST_FF_PULSE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ctrl[1:0] != 2'd1) |=> $stable(ff)); // R8
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> flags != 4'd0); // R7
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(8'h00) && bus_be[0] && !bus_wdata[7] && bus_wdata[5])
    |=> cnt == '0); // R5
endmodule

bind tri_mode_timer tri_mode_timer_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
  .bus_wdata(bus_wdata), .ctrl(ctrl_q), .cnt(cnt_q), .cmp_a(cmp_a),
  .flags(flag_q), .irq(irq_q), .ff(ff_q)
);

// File: tb/test_tri_mode_timer.sv
module test_tri_mode_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // {addr, be, wdata, expected readback}
  localparam logic [75:0] VEC [NV] = '{
    {8'h00, 4'h1, 32'h000000FF, 32'h000000EF},
    {8'h00, 4'hF, 32'h00000020, 32'h00000020},
    {8'h08, 4'hF, 32'hAB123456, 32'h00123456},
    {8'h0C, 4'h1, 32'h00000077, 32'h00FFFF77},
    {8'h10, 4'hF, 32'hFFFFFFFF, 32'h00008001},
    {8'h20, 4'hF, 32'h000000FF, 32'h00000007},
    {8'h30, 4'hF, 32'h0000FFFF, 32'h0000C001},
    {8'h40, 4'hF, 32'h0000FFFF, 32'h00008081},
    {8'h50, 4'hF, 32'hFFFFFFFF, 32'h00000000},
    {8'hF0, 4'hF, 32'h00001234, 32'h00000000},
    {8'h40, 4'h2, 32'h00000000, 32'h00000081},
    {8'h04, 4'hF, 32'h000000FF, 32'h00000000}
  };

  logic clk = 1'b0, rst = 1'b1, bus_we = 1'b0, ext_tick = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0] bus_be = '0;
  logic irq, pulse_out;
  int n_chk = 0, n_bad = 0;

  logic [1:0] m_mode;
  logic m_en, m_ivie, m_ivzc, m_pae, m_pbe, m_wie, m_wdis, m_ff, m_irq;
  logic [23:0] m_cnt, m_ca, m_cb;
  logic [3:0] m_st;

  tri_mode_timer i_tri_mode_timer (.clk(clk), .rst(rst), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .ext_tick(ext_tick), .irq(irq), .pulse_out(pulse_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  function automatic void m_step();
    logic [23:0] n;
    n = m_cnt + 24'd1;
    case (m_mode)
      2'd0: if (m_en && m_cnt != m_ca) begin
        if (n == m_ca) begin
          m_st[0] = 1'b1; if (m_ivie) m_irq = 1'b1;
          m_cnt = m_ivzc ? 24'd0 : m_ca;
        end else m_cnt = n;
      end
      2'd1: if (m_en) begin
        if (n == m_ca) begin
          m_ff = ~m_ff; m_st[1] = 1'b1; if (m_pae) m_irq = 1'b1; m_cnt = n;
        end else if (n == m_cb) begin
          m_ff = ~m_ff; m_st[2] = 1'b1; if (m_pbe) m_irq = 1'b1; m_cnt = 24'd0;
        end else m_cnt = n;
      end
      2'd2: if (m_en || !m_wdis) begin
        if (n == m_ca) begin
          m_st[3] = 1'b1; if (m_wie) m_irq = 1'b1; m_cnt = 24'd0;
        end else m_cnt = n;
      end
      default: m_cnt = m_cnt;
    endcase
  endfunction

  task automatic step_chk(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_tick = 1'b1;
      @(negedge clk); ext_tick = 1'b0;
      m_step();
      rd_chk({tag, " count"}, 8'hF0, 32'(m_cnt));
      rd_chk({tag, " status"}, 8'h04, 32'(m_st));
      chk({tag, " irq"}, 32'(irq), 32'(m_irq));
      chk({tag, " pulse_out"}, 32'(pulse_out), 32'(m_ff));
    end
  endtask

  task automatic clr_status();
    wr(8'h04, 32'h0, 4'h1);
    m_st = '0; m_irq = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3 reset state
    rd_chk("R3 reset cmpA", 8'h08, 32'h00FFFFFF);
    rd_chk("R3 reset cmpB", 8'h0C, 32'h00FFFFFF);
    rd_chk("R3 reset ctrl", 8'h00, 32'h0);
    rd_chk("R3 reset count", 8'hF0, 32'h0);
    chk("R3 reset irq", 32'(irq), 32'h0);
    chk("R3 reset pulse_out", 32'(pulse_out), 32'h0);

    // R1 R2 register map table
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][75:68], VEC[k][63:32], VEC[k][67:64]);
      rd(VEC[k][75:68], v);
      chk($sformatf("R1,R2 table[%0d]", k), v, VEC[k][31:0]);
    end

    // R3 one-cycle reset presets pulse_out from initial-level bit (set to 1 above)
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R3 preset pulse_out", 32'(pulse_out), 32'h1);
    rd_chk("R3 pulse setup cleared", 8'h30, 32'h0);
    rd_chk("R3 cmpA restored", 8'h08, 32'h00FFFFFF);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R3 second preset pulse_out", 32'(pulse_out), 32'h0);

    m_cnt = '0; m_st = '0; m_irq = 1'b0; m_ff = 1'b0;
    m_ivie = 1'b0; m_ivzc = 1'b0; m_pae = 1'b0; m_pbe = 1'b0; m_wie = 1'b0; m_wdis = 1'b0;
    m_cb = 24'hFFFFFF;

    // R6 R7 interval hold
    wr(8'h08, 32'd5, 4'hF); m_ca = 24'd5;
    wr(8'h10, 32'h8000, 4'hF); m_ivie = 1'b1;
    wr(8'h00, 32'h84, 4'h1); m_mode = 2'd0; m_en = 1'b1;
    step_chk("R6 interval", 5);
    chk("R7 irq at arrival", 32'(irq), 32'h1);
    clr_status();
    rd_chk("R12 status cleared", 8'h04, 32'h0);
    chk("R12 irq cleared", 32'(irq), 32'h0);
    step_chk("R7 hold no re-irq", 3);

    // R5 clear on disable, R6 clear-on-match
    wr(8'h00, 32'h24, 4'h1); m_en = 1'b0; m_cnt = '0;
    rd_chk("R5 counter cleared", 8'hF0, 32'h0);
    wr(8'h10, 32'h8001, 4'hF); m_ivzc = 1'b1;
    wr(8'h00, 32'h84, 4'h1); m_en = 1'b1;
    step_chk("R6 interval zero-clear", 7);
    clr_status();

    // R8 R9 pulse mode
    wr(8'h00, 32'h24, 4'h1); m_cnt = '0; m_en = 1'b0;
    wr(8'h08, 32'd2, 4'hF); m_ca = 24'd2;
    wr(8'h0C, 32'd4, 4'hF); m_cb = 24'd4;
    wr(8'h30, 32'h4000, 4'hF); m_pae = 1'b1;
    wr(8'h00, 32'h85, 4'h1); m_mode = 2'd1; m_en = 1'b1;
    step_chk("R8 pulse A", 2);
    clr_status();
    step_chk("R9 pulse B", 2);
    chk("R9 B irq disabled", 32'(irq), 32'h0);
    step_chk("R8 R9 pulse run", 5);
    clr_status();

    // R10 watchdog
    wr(8'h40, 32'h8000, 4'hF); m_wie = 1'b1; m_wdis = 1'b0;
    wr(8'h08, 32'd3, 4'hF); m_ca = 24'd3;
    wr(8'h00, 32'h26, 4'h1); m_mode = 2'd2; m_en = 1'b0; m_cnt = '0;
    step_chk("R10 watchdog runs disabled", 3);
    chk("R10 watchdog irq", 32'(irq), 32'h1);
    clr_status();
    step_chk("R10 watchdog partial", 1);
    wr(8'h40, 32'h8080, 4'hF); m_wdis = 1'b1;
    step_chk("R10 watchdog stopped", 3);

    // R11 mode 3
    wr(8'h00, 32'h87, 4'h1); m_mode = 2'd3; m_en = 1'b1;
    step_chk("R11 stopped mode", 3);

    // R4 internal clock, with and without prescaler
    wr(8'h00, 32'h20, 4'h1);
    wr(8'h08, 32'd100, 4'hF); wr(8'h0C, 32'd200, 4'hF);
    wr(8'h20, 32'd1, 4'hF);
    wr(8'h00, 32'hC1, 4'h1);
    repeat (3) @(negedge clk);
    rd_chk("R4 prescale not yet", 8'hF0, 32'd0);
    @(negedge clk);
    rd_chk("R4 prescale first step", 8'hF0, 32'd1);
    repeat (3) @(negedge clk);
    rd_chk("R4 prescale before second", 8'hF0, 32'd1);
    @(negedge clk);
    rd_chk("R4 prescale second step", 8'hF0, 32'd2);
    wr(8'h00, 32'h21, 4'h1);
    rd_chk("R5 clear before direct", 8'hF0, 32'd0);
    wr(8'h00, 32'h81, 4'h1);
    repeat (5) @(negedge clk);
    rd_chk("R4 direct clock", 8'hF0, 32'd5);

    summary();
    $finish;
  end
endmodule